// File: doc/BRIEF.md
# Read-Modify-Write Parity Write Engine

This block sits between write requesters and a 64-bit memory data path that stores one odd-parity bit per byte. Each request says where it comes from (the processor port or the PCI-side gather buffer), whether it is a processor burst beat, and which byte lanes it carries. From that and the configuration, the block decides how the write reaches memory. It can forward the requester's own parity. It can generate parity over the request data. Or it can run a merge sequence: latch the request, read the whole double word, check its parity, merge in the enabled lanes, regenerate all eight parity bits and write the full word back.

Memory is driven through a request/acknowledge pair. The block accepts one request at a time. While a merge sequence is running, it can ask the memory controller to keep the open page across both the read and the write.

Top module: `rmw_parity_engine`

## Requirements
- R1: Parity bit i covers data bits [8i+7:8i] and is odd: the byte and its bit together hold an odd number of ones. Writing an all-zero word with generated parity stores parity 8'hFF.
- R2: Merge mode is active when cfg_rmw_en=1 and cfg_wide=1. In that mode, a processor single-beat write (req_src=0, req_burst=0) does one read of the addressed word and then one write with mem_be=8'hFF. Lanes enabled in req_be take the request data. The other lanes keep the read data. All eight parity bits are regenerated.
- R3: A PCI-side write (req_src=1) with req_be=8'hFF is written once, with no read, using parity generated from the request data.
- R4: A PCI-side write with any other req_be goes through the same read-merge-write sequence as R2 while merge mode is active.
- R5: A processor burst beat (req_src=0, req_burst=1) is written once, with no read, carrying req_data, req_par and req_be unchanged, whatever the configuration.
- R6: Assume a memory that raises mem_ack one cycle after each new mem_req. A direct write drives mem_req with mem_we=1 in the first cycle after acceptance. A merge sequence drives its read in the second cycle and starts its write phase exactly six cycles later than a direct write would start.
- R7: When cfg_chk_en=1, each lane of the merge read whose stored parity mismatches sets err_flag and ORs that lane into err_lanes. Both stay set until reset. The merged write still completes with regenerated parity. When cfg_chk_en=0, no error is recorded.
- R8: When cfg_page_hold is nonzero, mem_page_hold stays high without a gap from the first read cycle through the write acknowledge of a merge sequence (7 cycles with the R6 memory). Otherwise, and for every direct write, it stays low.
- R9: With cfg_wide=0 or cfg_rmw_en=0, no read is ever issued. A processor single-beat write passes req_par and req_be through. A PCI-side write uses generated parity and req_be.
- R10: req_ready drops in the cycle after acceptance and returns high in the cycle after the write acknowledge. mem_req, mem_we and mem_addr stay steady until mem_ack.
- R11: After reset, req_ready=1, mem_req=0, mem_page_hold=0, err_flag=0 and err_lanes=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chk_en | input | 1 | Enable parity checking on reads |
| cfg_rmw_en | input | 1 | Enable merge sequences |
| cfg_wide | input | 1 | 1 = 64-bit data path, 0 = 32-bit (merge disabled) |
| cfg_page_hold | input | HOLD_W | Page hold setting; nonzero keeps the page open during a merge |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_src | input | 1 | 0 = processor port, 1 = PCI-side buffer |
| req_burst | input | 1 | Request is a processor burst beat |
| req_be | input | DATA_W/LANE_W | Byte lane enables |
| req_addr | input | ADDR_W | Double-word address |
| req_data | input | DATA_W | Write data |
| req_par | input | DATA_W/LANE_W | Requester-supplied parity |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_be | output | DATA_W/LANE_W | Memory lane enables |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wpar | output | DATA_W/LANE_W | Memory write parity |
| mem_ack | input | 1 | Memory access acknowledge |
| mem_rdata | input | DATA_W | Memory read data (valid with mem_ack) |
| mem_rpar | input | DATA_W/LANE_W | Memory read parity (valid with mem_ack) |
| mem_page_hold | output | 1 | Keep the memory page open |
| err_flag | output | 1 | Sticky parity error flag |
| err_lanes | output | DATA_W/LANE_W | Sticky mask of failing lanes |

## Verification
Requests are drawn at random across source, burst flag, lane enables and configuration. Three directed sets are mixed in:
- Full-lane PCI writes, which tell parity generation apart from merging.
- Partial processor and PCI writes, which tell merging apart from masked direct writes.
- Burst beats carrying deliberately wrong parity, which show pass-through and later expose checking during a merge read.

The narrow-path and merge-off configurations show that no read is ever issued there. The read and write offsets and the page-hold cycle count separate the six-cycle sequence from direct writes, and a zero hold setting shows that the hold stays low.

// File: rtl/rmw_pkg.sv
// Package: shared types for the read-modify-write parity engine.
// Assumes: one request in flight; the sequencer states are ordered as used.
package rmw_pkg;
    // Sequencer states; a merge walks LATCH..GEN, a direct write goes to WR.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LATCH,
        ST_RD,
        ST_CHK,
        ST_MERGE,
        ST_GEN,
        ST_WR
    } seq_state_e;

    // How the latched request reaches memory.
    typedef enum logic [1:0] {
        WM_PASS,  // requester parity forwarded
        WM_GEN,   // parity generated from request data
        WM_RMW    // read, check, merge, regenerate, write
    } wr_mode_e;

    localparam logic SRC_CPU = 1'b0;
    localparam logic SRC_PCI = 1'b1;
endpackage

// File: rtl/rmw_parity_lanes.sv
// Module: per-lane odd parity generator.
// Each output bit is set so that the lane plus that bit holds an odd
// number of ones. Assumes DATA_W is a whole multiple of LANE_W.
module rmw_parity_lanes #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]        data_i,
    output logic [DATA_W/LANE_W-1:0] par_o
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Odd parity of one lane.
        assign par_o[g] = ~^data_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/rmw_lane_merge.sv
// Module: lane merge between request data and data read from memory.
// An enabled lane takes the new data; any other lane keeps the old data.
// Assumes both words are aligned to the same address.
module rmw_lane_merge #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0]        new_i,
    input  logic [DATA_W-1:0]        old_i,
    input  logic [DATA_W/LANE_W-1:0] be_i,
    output logic [DATA_W-1:0]        merged_o
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Choose the source of one lane.
        assign merged_o[g*LANE_W +: LANE_W] =
            be_i[g] ? new_i[g*LANE_W +: LANE_W] : old_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/rmw_seq_ctrl.sv
// Module: sequencer for direct writes and merge sequences.
// It issues the memory read and write requests, produces one-cycle
// strobes for the datapath stages and owns the page-hold output.
// Assumes the memory keeps mem_ack low until it has seen mem_req.
module rmw_seq_ctrl
    import rmw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,      // request valid
    input  logic is_rmw_i,     // selected mode needs a merge
    input  logic hold_en_i,    // page hold setting is nonzero
    input  logic mem_ack,
    output logic req_ready,
    output logic mem_req,
    output logic mem_we,
    output logic mem_page_hold,
    output logic cap_rd_o,     // capture read data this cycle
    output logic do_chk_o,
    output logic do_merge_o,
    output logic do_gen_o
);
    seq_state_e state_q, state_d;
    logic       hold_q;
    logic       accept;

    assign accept = start_i && (state_q == ST_IDLE);

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = is_rmw_i ? ST_LATCH : ST_WR;
            ST_LATCH: state_d = ST_RD;
            ST_RD:    if (mem_ack) state_d = ST_CHK;
            ST_CHK:   state_d = ST_MERGE;
            ST_MERGE: state_d = ST_GEN;
            ST_GEN:   state_d = ST_WR;
            ST_WR:    if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Page hold request, set on accepting a merge and cleared on the write ack.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hold_q <= 1'b0;
        else if (accept)                      hold_q <= is_rmw_i && hold_en_i;
        else if (state_q == ST_WR && mem_ack) hold_q <= 1'b0;
    end

    // Decode outputs from the state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req       = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we        = (state_q == ST_WR);
        mem_page_hold = hold_q && (state_q != ST_IDLE) && (state_q != ST_LATCH);
        cap_rd_o      = (state_q == ST_RD) && mem_ack;
        do_chk_o      = (state_q == ST_CHK);
        do_merge_o    = (state_q == ST_MERGE);
        do_gen_o      = (state_q == ST_GEN);
    end

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) (start_i && req_ready) |=> !req_ready); // R10
    AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we))); // R10
    AST_HOLD_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n) (mem_page_hold && !(mem_we && mem_ack)) |=> mem_page_hold); // R8
    AST_RMW_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n) cap_rd_o |=> (!mem_req && !req_ready)); // R6
endmodule

// File: rtl/rmw_parity_engine.sv
// Module: top of the read-modify-write parity engine.
// It selects a write mode for each request, latches the request, captures
// and checks the merge read, merges lanes, regenerates parity and drives
// the memory write. Assumes the configuration is steady while a request
// is in flight and that req_addr is a double-word address.
module rmw_parity_engine
    import rmw_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 16,
    parameter int HOLD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_chk_en,
    input  logic                     cfg_rmw_en,
    input  logic                     cfg_wide,
    input  logic [HOLD_W-1:0]        cfg_page_hold,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_src,
    input  logic                     req_burst,
    input  logic [DATA_W/LANE_W-1:0] req_be,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_data,
    input  logic [DATA_W/LANE_W-1:0] req_par,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [DATA_W/LANE_W-1:0] mem_be,
    output logic [DATA_W-1:0]        mem_wdata,
    output logic [DATA_W/LANE_W-1:0] mem_wpar,
    input  logic                     mem_ack,
    input  logic [DATA_W-1:0]        mem_rdata,
    input  logic [DATA_W/LANE_W-1:0] mem_rpar,
    output logic                     mem_page_hold,
    output logic                     err_flag,
    output logic [DATA_W/LANE_W-1:0] err_lanes
);
    localparam int LANES = DATA_W / LANE_W;
    localparam logic [LANES-1:0] ALL_LANES = {LANES{1'b1}};

    wr_mode_e           mode_sel, lat_mode;
    logic               rmw_active, accept;
    logic [ADDR_W-1:0]  lat_addr;
    logic [DATA_W-1:0]  lat_data, rd_data, mrg_data, merged;
    logic [LANES-1:0]   lat_be, lat_par, rd_par, mrg_par;
    logic [LANES-1:0]   lat_gen_par, rd_chk_par, mrg_gen_par, bad_lanes;
    logic               cap_rd, do_chk, do_merge, do_gen;

    // Assertion helper: flags lanes whose parity is not odd.
    function automatic logic [LANES-1:0] lane_odd_fail(input logic [DATA_W-1:0] d,
                                                       input logic [LANES-1:0] p);
        logic [LANES-1:0] f;
        for (int i = 0; i < LANES; i++)
            f[i] = (($countones({p[i], d[i*LANE_W +: LANE_W]}) % 2) == 0);
        return f;
    endfunction

    // Merge mode is only allowed on the wide path.
    assign rmw_active = cfg_rmw_en && cfg_wide;
    assign accept     = req_valid && req_ready;

    // Pick the write mode from the requester type and configuration.
    always_comb begin
        if (req_src == SRC_CPU) begin
            if (req_burst)       mode_sel = WM_PASS;
            else if (rmw_active) mode_sel = WM_RMW;
            else                 mode_sel = WM_PASS;
        end else begin
            if (req_be == ALL_LANES || !rmw_active) mode_sel = WM_GEN;
            else                                    mode_sel = WM_RMW;
        end
    end

    // Latch the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_be   <= '0;
            lat_par  <= '0;
            lat_mode <= WM_PASS;
        end else if (accept) begin
            lat_addr <= req_addr;
            lat_data <= req_data;
            lat_be   <= req_be;
            lat_par  <= req_par;
            lat_mode <= mode_sel;
        end
    end

    // Capture the double word returned by the merge read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_par  <= '0;
        end else if (cap_rd) begin
            rd_data <= mem_rdata;
            rd_par  <= mem_rpar;
        end
    end

    rmw_parity_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk_par (
        .data_i (rd_data),
        .par_o  (rd_chk_par)
    );

    assign bad_lanes = rd_chk_par ^ rd_par;

    // Record parity mismatches from the read phase; sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag  <= 1'b0;
            err_lanes <= '0;
        end else if (do_chk && cfg_chk_en && (bad_lanes != '0)) begin
            err_flag  <= 1'b1;
            err_lanes <= err_lanes | bad_lanes;
        end
    end

    rmw_lane_merge #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_merge (
        .new_i    (lat_data),
        .old_i    (rd_data),
        .be_i     (lat_be),
        .merged_o (merged)
    );

    // Register the merged double word.
    always_ff @(posedge clk) begin
        if (!rst_n)        mrg_data <= '0;
        else if (do_merge) mrg_data <= merged;
    end

    rmw_parity_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mrg_par (
        .data_i (mrg_data),
        .par_o  (mrg_gen_par)
    );

    // Register the regenerated parity of the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n)      mrg_par <= '0;
        else if (do_gen) mrg_par <= mrg_gen_par;
    end

    rmw_parity_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_req_par (
        .data_i (lat_data),
        .par_o  (lat_gen_par)
    );

    rmw_seq_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (req_valid),
        .is_rmw_i      (mode_sel == WM_RMW),
        .hold_en_i     (cfg_page_hold != '0),
        .mem_ack       (mem_ack),
        .req_ready     (req_ready),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_page_hold (mem_page_hold),
        .cap_rd_o      (cap_rd),
        .do_chk_o      (do_chk),
        .do_merge_o    (do_merge),
        .do_gen_o      (do_gen)
    );

    // Steer memory write data, parity and lane enables by mode.
    always_comb begin
        mem_addr  = lat_addr;
        mem_wdata = (lat_mode == WM_RMW) ? mrg_data : lat_data;
        mem_be    = (lat_mode == WM_RMW) ? ALL_LANES : lat_be;
        unique case (lat_mode)
            WM_GEN:  mem_wpar = lat_gen_par;
            WM_RMW:  mem_wpar = mrg_par;
            default: mem_wpar = lat_par;
        endcase
    end

    AST_WRITE_PARITY_ODD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && lat_mode != WM_PASS) |-> (lane_odd_fail(mem_wdata, mem_wpar) == '0)); // R1
    AST_MERGE_WRITES_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_we && lat_mode == WM_RMW) |-> (mem_be == ALL_LANES)); // R2
    AST_READ_ONLY_IN_MERGE: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_we) |-> (lat_mode == WM_RMW)); // R9
    AST_NARROW_GOES_DIRECT: assert property (@(posedge clk) disable iff (!rst_n) (accept && !cfg_wide) |=> (mem_req && mem_we)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err_flag |=> err_flag); // R7
    AST_ADDR_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ack) |=> $stable(mem_addr)); // R10
endmodule

// File: tb/rmw_parity_engine_tb_top.sv
`timescale 1ns/1ps
module rmw_parity_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_chk_en = 1'b1, cfg_rmw_en = 1'b1, cfg_wide = 1'b1;
    logic [3:0]  cfg_page_hold = 4'd3;
    logic        req_valid = 1'b0, req_src = 1'b0, req_burst = 1'b0;
    logic [7:0]  req_be = 8'h00, req_par = 8'h00;
    logic [15:0] req_addr = 16'h0;
    logic [63:0] req_data = 64'h0;
    logic        req_ready, mem_req, mem_we, mem_ack, mem_page_hold, err_flag;
    logic [15:0] mem_addr;
    logic [7:0]  mem_be, mem_wpar, mem_rpar, err_lanes;
    logic [63:0] mem_wdata, mem_rdata;

    logic [63:0] mem_d [16];
    logic [7:0]  mem_p [16];
    logic [63:0] exp_d [16];
    logic [7:0]  exp_p [16];
    logic [7:0]  exp_err_lanes = 8'h00;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    rmw_parity_engine dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_chk_en(cfg_chk_en), .cfg_rmw_en(cfg_rmw_en), .cfg_wide(cfg_wide),
        .cfg_page_hold(cfg_page_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_burst(req_burst), .req_be(req_be), .req_addr(req_addr),
        .req_data(req_data), .req_par(req_par),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_wpar(mem_wpar), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_rpar(mem_rpar), .mem_page_hold(mem_page_hold),
        .err_flag(err_flag), .err_lanes(err_lanes)
    );

    function automatic logic [7:0] odd_par(input logic [63:0] d);
        logic [7:0] p;
        for (int i = 0; i < 8; i++) begin
            int ones = 0;
            for (int b = 0; b < 8; b++) ones += int'(d[i*8+b]);
            p[i] = (ones % 2 == 0);
        end
        return p;
    endfunction

    function automatic logic [63:0] init_word(input int i);
        logic [7:0] b = i[7:0];
        return 64'h0F1E_2D3C_4B5A_6978 ^ {8{b}};
    endfunction

    // Memory model: one-cycle acknowledge, lane-masked writes.
    assign mem_rdata = mem_d[mem_addr[3:0]];
    assign mem_rpar  = mem_p[mem_addr[3:0]];
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            for (int i = 0; i < 16; i++) begin
                mem_d[i] <= init_word(i);
                mem_p[i] <= odd_par(init_word(i));
            end
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack && mem_we)
                for (int i = 0; i < 8; i++)
                    if (mem_be[i]) begin
                        mem_d[mem_addr[3:0]][i*8 +: 8] <= mem_wdata[i*8 +: 8];
                        mem_p[mem_addr[3:0]][i]        <= mem_wpar[i];
                    end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One write request with its expected effects computed from the requirements.
    task automatic run_wr(input logic src, input logic burst, input logic [7:0] be,
                          input logic [3:0] idx, input logic [63:0] data, input logic [7:0] par);
        logic        rmw_act, is_rmw;
        logic [63:0] nd, wd;
        logic [7:0]  np, wp;
        string       tag;
        int off, rd_off, wr_off, hold_n;
        logic first_ready;
        rmw_act = cfg_rmw_en && cfg_wide;
        is_rmw  = rmw_act && ((src == 1'b0 && !burst) || (src == 1'b1 && be != 8'hFF));
        nd = exp_d[idx];
        np = exp_p[idx];
        if (is_rmw) begin
            for (int i = 0; i < 8; i++) if (be[i]) nd[i*8 +: 8] = data[i*8 +: 8];
            np = odd_par(nd);
            if (cfg_chk_en) exp_err_lanes = exp_err_lanes | (odd_par(exp_d[idx]) ^ exp_p[idx]);
            tag = (src == 1'b1) ? "R4" : "R2";
        end else begin
            wd = data;
            wp = (src == 1'b1) ? odd_par(data) : par;
            for (int i = 0; i < 8; i++)
                if (be[i]) begin
                    nd[i*8 +: 8] = wd[i*8 +: 8];
                    np[i]        = wp[i];
                end
            if (src == 1'b0 && burst) tag = "R5";
            else if (!rmw_act)        tag = "R9";
            else                      tag = "R3";
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_src = src; req_burst = burst; req_be = be; req_addr = {12'h0, idx};
        req_data = data; req_par = par; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        off = 0; rd_off = -1; wr_off = -1; hold_n = 0;
        first_ready = req_ready;
        while (1) begin
            if (mem_req && !mem_we && rd_off < 0) rd_off = off;
            if (mem_req && mem_we && wr_off < 0)  wr_off = off;
            if (mem_page_hold) hold_n++;
            if (req_ready) break;
            off++;
            if (off > 40) break;
            @(negedge clk);
        end
        check(first_ready == 1'b0, "R10 busy after accept", 64'(first_ready), 64'd0);
        check(off == (is_rmw ? 8 : 2), "R10 ready return offset", 64'(off), 64'(is_rmw ? 8 : 2));
        check(mem_d[idx] == nd, {tag, " stored data"}, mem_d[idx], nd);
        check(mem_p[idx] == np, {tag, " stored parity"}, 64'(mem_p[idx]), 64'(np));
        check(rd_off == (is_rmw ? 1 : -1), is_rmw ? "R6 read offset" : "R9 no read phase",
              64'(rd_off), 64'(is_rmw ? 1 : -1));
        check(wr_off == (is_rmw ? 6 : 0), "R6 write offset", 64'(wr_off), 64'(is_rmw ? 6 : 0));
        check(hold_n == ((is_rmw && cfg_page_hold != 4'd0) ? 7 : 0), "R8 page hold cycles",
              64'(hold_n), 64'((is_rmw && cfg_page_hold != 4'd0) ? 7 : 0));
        check(err_lanes == exp_err_lanes, "R7 error lanes", 64'(err_lanes), 64'(exp_err_lanes));
        check(err_flag == (exp_err_lanes != 8'h00), "R7 error flag", 64'(err_flag), 64'(exp_err_lanes != 8'h00));
        exp_d[idx] = nd;
        exp_p[idx] = np;
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) begin
            exp_d[i] = init_word(i);
            exp_p[i] = odd_par(init_word(i));
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
        check(mem_req == 1'b0, "R11 no request after reset", 64'(mem_req), 64'd0);
        check(mem_page_hold == 1'b0, "R11 hold low after reset", 64'(mem_page_hold), 64'd0);
        check({err_flag, err_lanes} == 9'h0, "R11 errors clear after reset", 64'({err_flag, err_lanes}), 64'd0);

        // Full-lane PCI write of zeros: generated odd parity is all ones.
        run_wr(1'b1, 1'b0, 8'hFF, 4'd1, 64'h0, 8'h00);
        check(mem_p[1] == 8'hFF, "R1 zero word parity", 64'(mem_p[1]), 64'hFF);
        run_wr(1'b0, 1'b0, 8'h0F, 4'd2, 64'hA5A5_5A5A_1234_5678, 8'h00);
        run_wr(1'b1, 1'b0, 8'h30, 4'd3, 64'hDEAD_BEEF_CAFE_F00D, 8'h00);
        // Burst beat carrying wrong parity on lanes 2 and 5, then a merge over it.
        d = 64'h1122_3344_5566_7788;
        run_wr(1'b0, 1'b1, 8'hFF, 4'd5, d, odd_par(d) ^ 8'h24);
        run_wr(1'b0, 1'b0, 8'h01, 4'd5, 64'hFFFF_FFFF_FFFF_FFEE, 8'h00);
        check(mem_p[5] == odd_par(mem_d[5]), "R7 merged parity regenerated", 64'(mem_p[5]), 64'(odd_par(mem_d[5])));
        cfg_page_hold = 4'd0;
        run_wr(1'b0, 1'b0, 8'hF0, 4'd6, 64'h0102_0304_0506_0708, 8'h00);
        cfg_page_hold = 4'd2;
        cfg_chk_en = 1'b0;
        d = 64'h8877_6655_4433_2211;
        run_wr(1'b0, 1'b1, 8'hFF, 4'd7, d, odd_par(d) ^ 8'h81);
        run_wr(1'b0, 1'b0, 8'h02, 4'd7, 64'h0, 8'h00);
        cfg_chk_en = 1'b1;
        cfg_wide = 1'b0;
        run_wr(1'b0, 1'b0, 8'h3C, 4'd8, 64'h0BAD_F00D_0BAD_F00D, 8'h5A);
        run_wr(1'b1, 1'b0, 8'h81, 4'd9, 64'h7777_8888_9999_AAAA, 8'h00);
        cfg_wide = 1'b1;
        cfg_rmw_en = 1'b0;
        run_wr(1'b1, 1'b0, 8'h0C, 4'd10, 64'h1357_9BDF_2468_ACE0, 8'h00);
        cfg_rmw_en = 1'b1;

        for (int n = 0; n < 80; n++) begin
            logic       s, b;
            logic [7:0] be;
            cfg_chk_en    = ($urandom % 4) != 0;
            cfg_rmw_en    = ($urandom % 4) != 0;
            cfg_wide      = ($urandom % 5) != 0;
            cfg_page_hold = 4'($urandom % 3);
            s  = 1'($urandom % 2);
            b  = (s == 1'b0) && (($urandom % 4) == 0);
            be = (($urandom % 3) == 0) ? 8'hFF : 8'($urandom);
            run_wr(s, b, be, 4'($urandom % 16), {$urandom, $urandom}, 8'($urandom));
        end
        check(err_flag == 1'b1, "R7 flag still set at end", 64'(err_flag), 64'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule